// File: doc/BRIEF.md
# Four-Axis Strided Max Pooling Engine

This engine computes max pooling over a four-axis tensor of single-precision floats held in word-addressed memory. Software supplies the input and output extents, window size, stride and low-side padding for every axis, along with two base addresses, and then pulses start. The engine walks every output element in turn. For each one it gathers the clipped input window through a read port that can stall, keeps a running maximum, and stores the result through a write port that can also stall. A single done pulse follows the final store.

Each axis has its own stride and its own window size, so neighbouring windows may overlap. Window bounds are moved down by the padding and then clipped to the input extent. Windows at the edges therefore shrink, and a window clipped to nothing yields negative infinity. Floats are ordered with pure integer logic, with no floating-point unit.

Top module: `pool4d_engine`

## Requirements
- R1: Each output element equals the float maximum of the input elements in its window. On axis a the window starts at out_index·stride − pad and covers win elements. Stride and window are set separately per axis, so windows may overlap.
- R2: On every axis the window start is clamped below at 0. The exclusive window end is clamped above at the input extent of that axis.
- R3: A window that is empty on any axis produces 0xFF800000 (negative infinity), and no read is issued for it.
- R4: Floats are ordered by an integer key: bitwise inverse when bit 31 is set, otherwise bit 31 flipped. A candidate replaces the running maximum only when its key is strictly larger, so +0 ranks above −0.
- R5: The element at (x,y,z,p) has linear index ((x·Y+y)·Z+z)·P+p. Its byte address is base + 4·index, using the input extents for reads and the output extents for writes. Each configuration port packs axis a (0=x, 1=y, 2=z, 3=p) in bits [12a+11:12a].
- R6: A read is accepted on a rising edge where rd_req is high and rd_stall is low. rd_data is taken one cycle after acceptance. While stalled, rd_req and rd_addr hold.
- R7: Every output element is written exactly once. While wr_stall is high, wr_req, wr_addr and wr_data hold.
- R8: done is high for exactly one cycle, namely the cycle after the last write is accepted.
- R9: Configuration is captured only when start is high in the idle state. Start pulses and configuration changes during a run have no effect on that run.
- R10: After reset, rd_req, wr_req and done are low.
- R11: rd_req and wr_req are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| cfg_in_dim | input | 48 | Input extent per axis |
| cfg_out_dim | input | 48 | Output extent per axis (nonzero) |
| cfg_win | input | 48 | Window size per axis |
| cfg_stride | input | 48 | Stride per axis |
| cfg_pad | input | 48 | Low-side padding per axis |
| cfg_in_base | input | 32 | Byte base of the input tensor |
| cfg_out_base | input | 32 | Byte base of the output tensor |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_stall | input | 1 | Memory cannot accept a read this cycle |
| rd_data | input | 32 | Read data, valid one cycle after acceptance |
| wr_req | output | 1 | Write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Pooled value |
| wr_stall | input | 1 | Memory cannot accept a write this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
A miscounted window or output counter appears at the ports within one element. It shows as a read address outside the input tensor, a wrong number of writes, or a stored value that differs from the model. A bad running maximum or a bad key ordering shows up in the next write, because each written value depends on the comparison state of one window only. Read and write stalls are drawn at random, so a handshake that drops or repeats an access corrupts a value or changes the write count in the same run.

// File: rtl/pool_pkg.sv
package pool_pkg;
  localparam int DIM_W  = 12;
  localparam int ADDR_W = 32;
  localparam int NAX    = 4;
  localparam int SW     = 2 * DIM_W + 2;
  localparam logic [31:0] NEG_INF = 32'hFF80_0000;

  typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_READ, ST_WAIT, ST_WRITE} pool_st_t;

  // monotone integer image of a float
  function automatic logic [31:0] order_key(input logic [31:0] f);
    return f[31] ? ~f : (f ^ 32'h8000_0000);
  endfunction

  function automatic logic [DIM_W-1:0] win_start(input logic [DIM_W-1:0] o, s, pad);
    logic signed [SW-1:0] v;
    v = $signed(SW'(o)) * $signed(SW'(s)) - $signed(SW'(pad));
    if (v < 0) return '0;
    if (v > $signed(SW'({DIM_W{1'b1}}))) return '1;
    return v[DIM_W-1:0];
  endfunction

  function automatic logic [DIM_W-1:0] win_stop(input logic [DIM_W-1:0] o, s, w, pad, n);
    logic signed [SW-1:0] v;
    v = $signed(SW'(o)) * $signed(SW'(s)) + $signed(SW'(w)) - $signed(SW'(pad));
    if (v < 0) return '0;
    if (v > $signed(SW'(n))) return n;
    return v[DIM_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] lin_addr(input logic [ADDR_W-1:0] base,
                                                 input logic [NAX*DIM_W-1:0] idx,
                                                 input logic [NAX*DIM_W-1:0] dims);
    logic [ADDR_W-1:0] acc;
    acc = '0;
    for (int a = 0; a < NAX; a++)
      acc = acc * ADDR_W'(dims[a*DIM_W +: DIM_W]) + ADDR_W'(idx[a*DIM_W +: DIM_W]);
    return base + (acc << 2);
  endfunction
endpackage

// File: rtl/pool_odometer.sv
module pool_odometer #(
  parameter int NAX = 4,
  parameter int W   = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [NAX*W-1:0] lo,
  input  logic [NAX*W-1:0] hi,
  output logic [NAX*W-1:0] cnt,
  output logic           last
);
  logic [NAX*W-1:0] cnt_q, nxt;
  logic [NAX-1:0]   wrap;

  for (genvar a = 0; a < NAX; a++) begin : g_wrap
    assign wrap[a] = ({1'b0, cnt_q[a*W +: W]} + 1'b1) >= {1'b0, hi[a*W +: W]};
  end
  assign last = &wrap;

  // innermost digit is the highest index
  always_comb begin
    logic carry;
    carry = 1'b1;
    nxt   = cnt_q;
    for (int a = NAX - 1; a >= 0; a--) begin
      if (carry) begin
        if (wrap[a]) nxt[a*W +: W] = lo[a*W +: W];
        else begin
          nxt[a*W +: W] = cnt_q[a*W +: W] + 1'b1;
          carry = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= lo;
    else if (step) cnt_q <= nxt;
  end
  assign cnt = cnt_q;
endmodule

// File: rtl/pool_maxkey.sv
module pool_maxkey
  import pool_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        upd,
  input  logic [31:0] din,
  output logic [31:0] max_val
);
  logic [31:0] max_q;
  logic        take;

  assign take = upd && (order_key(din) > order_key(max_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     max_q <= NEG_INF;
    else if (clear) max_q <= NEG_INF;
    else if (take)  max_q <= din;
  end
  assign max_val = max_q;

  // R4
  max_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> order_key(max_q) >= order_key($past(din)));
endmodule

// File: rtl/pool4d_engine.sv
module pool4d_engine
  import pool_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NAX*DIM_W-1:0]   cfg_in_dim,
  input  logic [NAX*DIM_W-1:0]   cfg_out_dim,
  input  logic [NAX*DIM_W-1:0]   cfg_win,
  input  logic [NAX*DIM_W-1:0]   cfg_stride,
  input  logic [NAX*DIM_W-1:0]   cfg_pad,
  input  logic [ADDR_W-1:0]      cfg_in_base,
  input  logic [ADDR_W-1:0]      cfg_out_base,
  output logic                   rd_req,
  output logic [ADDR_W-1:0]      rd_addr,
  input  logic                   rd_stall,
  input  logic [31:0]            rd_data,
  output logic                   wr_req,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [31:0]            wr_data,
  input  logic                   wr_stall,
  output logic                   done
);
  pool_st_t state;
  logic [NAX*DIM_W-1:0] in_dim_q, out_dim_q, win_q, str_q, pad_q;
  logic [ADDR_W-1:0]    ibase_q, obase_q;
  logic [NAX*DIM_W-1:0] ocnt, wcnt, wlo, whi;
  logic [NAX-1:0]       ax_empty;
  logic out_last, win_last, win_empty, done_q;

  // named internal events
  logic start_acc, rd_acc, rd_done, wr_acc, run_end;
  assign start_acc = start && (state == ST_IDLE);
  assign rd_req    = (state == ST_READ);
  assign wr_req    = (state == ST_WRITE);
  assign rd_acc    = rd_req && !rd_stall;
  assign rd_done   = (state == ST_WAIT);
  assign wr_acc    = wr_req && !wr_stall;
  assign run_end   = wr_acc && out_last;

  pool_odometer #(.NAX(NAX), .W(DIM_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .step(wr_acc && !out_last),
    .lo('0), .hi(out_dim_q), .cnt(ocnt), .last(out_last));

  for (genvar a = 0; a < NAX; a++) begin : g_ax
    assign wlo[a*DIM_W +: DIM_W] = win_start(ocnt[a*DIM_W +: DIM_W], str_q[a*DIM_W +: DIM_W],
                                             pad_q[a*DIM_W +: DIM_W]);
    assign whi[a*DIM_W +: DIM_W] = win_stop(ocnt[a*DIM_W +: DIM_W], str_q[a*DIM_W +: DIM_W],
                                            win_q[a*DIM_W +: DIM_W], pad_q[a*DIM_W +: DIM_W],
                                            in_dim_q[a*DIM_W +: DIM_W]);
    assign ax_empty[a] = wlo[a*DIM_W +: DIM_W] >= whi[a*DIM_W +: DIM_W];
  end
  assign win_empty = |ax_empty;

  pool_odometer #(.NAX(NAX), .W(DIM_W)) u_win (
    .clk(clk), .rst_n(rst_n), .load(state == ST_SETUP), .step(rd_done && !win_last),
    .lo(wlo), .hi(whi), .cnt(wcnt), .last(win_last));

  pool_maxkey u_max (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_SETUP), .upd(rd_done),
    .din(rd_data), .max_val(wr_data));

  assign rd_addr = lin_addr(ibase_q, wcnt, in_dim_q);
  assign wr_addr = lin_addr(obase_q, ocnt, out_dim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      in_dim_q <= '0; out_dim_q <= '0; win_q <= '0; str_q <= '0; pad_q <= '0;
      ibase_q <= '0; obase_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= run_end;
      case (state)
        ST_IDLE: if (start_acc) begin
          in_dim_q <= cfg_in_dim; out_dim_q <= cfg_out_dim; win_q <= cfg_win;
          str_q <= cfg_stride; pad_q <= cfg_pad;
          ibase_q <= cfg_in_base; obase_q <= cfg_out_base;
          state <= ST_SETUP;
        end
        ST_SETUP: state <= win_empty ? ST_WRITE : ST_READ;
        ST_READ:  if (rd_acc) state <= ST_WAIT;
        ST_WAIT:  state <= win_last ? ST_WRITE : ST_READ;
        ST_WRITE: if (wr_acc) state <= out_last ? ST_IDLE : ST_SETUP;
        default:  state <= ST_IDLE;
      endcase
    end
  end
  assign done = done_q;

  // R11
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_req && wr_req));
  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_stall |=> rd_req && $stable(rd_addr));
  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_stall |=> wr_req && $stable(wr_addr) && $stable(wr_data));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && start |=> $stable(in_dim_q) && $stable(win_q) && $stable(ibase_q));
endmodule

// File: tb/pool4d_engine_bench.sv
module pool4d_engine_bench;
  localparam int DW = 12;
  localparam logic [31:0] IBASE = 32'h0000_1000;
  localparam logic [31:0] OBASE = 32'h0002_0000;
  localparam int MEMN = 4096;

  logic clk = 0, rst_n = 0, start = 0;
  logic [4*DW-1:0] cfg_in_dim = '0, cfg_out_dim = '0, cfg_win = '0, cfg_stride = '0, cfg_pad = '0;
  logic [31:0] cfg_in_base = IBASE, cfg_out_base = OBASE;
  logic rd_req, wr_req, done;
  logic [31:0] rd_addr, wr_addr, wr_data;
  logic rd_stall = 0, wr_stall = 0;
  logic [31:0] rd_data = '0;

  always #2 clk = ~clk;

  pool4d_engine u_pool4d_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_in_dim(cfg_in_dim), .cfg_out_dim(cfg_out_dim), .cfg_win(cfg_win),
    .cfg_stride(cfg_stride), .cfg_pad(cfg_pad),
    .cfg_in_base(cfg_in_base), .cfg_out_base(cfg_out_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_stall(rd_stall), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
    .done(done));

  logic [31:0] imem [MEMN];
  logic [31:0] omem [MEMN];
  int ind[4], outd[4], wn[4], st[4], pd[4];
  int checks = 0, fails = 0;
  int done_seen, wr_count, addr_err, width_err, excl_err;
  bit acc_pend = 0, prev_done = 0, stall_on = 0;
  int acc_idx = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model, all updates away from the rising edge
  always @(negedge clk) begin
    if (acc_pend) rd_data = imem[acc_idx];
    rd_stall = stall_on && ($urandom % 3 == 0);
    wr_stall = stall_on && ($urandom % 3 == 0);
    acc_pend = rd_req && !rd_stall;
    if (acc_pend) begin
      acc_idx = int'((rd_addr - IBASE) >> 2);
      if (rd_addr < IBASE || acc_idx >= MEMN || rd_addr[1:0] != 0) begin addr_err++; acc_idx = 0; end
    end
    if (wr_req && !wr_stall) begin
      int oi;
      oi = int'((wr_addr - OBASE) >> 2);
      if (wr_addr < OBASE || oi >= MEMN) addr_err++;
      else omem[oi] = wr_data;
      wr_count++;
    end
    if (rd_req && wr_req) excl_err++;
    if (done && prev_done) width_err++;
    if (done) done_seen++;
    prev_done = done;
  end

  function automatic bit fgt(input logic [31:0] a, input logic [31:0] b);
    if (a == b) return 0;
    if (a[31] != b[31]) return !a[31];
    if (!a[31]) return a[30:0] > b[30:0];
    return a[30:0] < b[30:0];
  endfunction

  function automatic logic [4*DW-1:0] pack(input int v[4]);
    logic [4*DW-1:0] r;
    for (int a = 0; a < 4; a++) r[a*DW +: DW] = v[a][DW-1:0];
    return r;
  endfunction

  function automatic int lin(input int c[4], input int d[4]);
    return ((c[0]*d[1] + c[1])*d[2] + c[2])*d[3] + c[3];
  endfunction

  function automatic logic [31:0] expect_at(input int o[4]);
    int lo[4], hi[4], c[4];
    logic [31:0] m;
    m = 32'hFF80_0000;
    for (int a = 0; a < 4; a++) begin
      lo[a] = o[a]*st[a] - pd[a]; if (lo[a] < 0) lo[a] = 0;
      hi[a] = o[a]*st[a] + wn[a] - pd[a]; if (hi[a] > ind[a]) hi[a] = ind[a];
    end
    for (int x = lo[0]; x < hi[0]; x++)
      for (int y = lo[1]; y < hi[1]; y++)
        for (int z = lo[2]; z < hi[2]; z++)
          for (int p = lo[3]; p < hi[3]; p++) begin
            c[0] = x; c[1] = y; c[2] = z; c[3] = p;
            if (fgt(imem[lin(c, ind)], m)) m = imem[lin(c, ind)];
          end
    return m;
  endfunction

  function automatic logic [31:0] rnd_float();
    logic [7:0] e;
    e = 8'(1 + ($urandom % 254));
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  function automatic logic [31:0] tie_float();
    case ($urandom % 5)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'hBF80_0000;
      3: return 32'hC000_0000;
      default: return 32'hFF80_0000;
    endcase
  endfunction

  task automatic set6(output int v[4], input int a, b, c, d);
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
  endtask

  task automatic run_case(input string req, input bit poke);
    int nout, cyc;
    int o[4];
    nout = outd[0]*outd[1]*outd[2]*outd[3];
    for (int i = 0; i < MEMN; i++) omem[i] = 32'hDEAD_BEEF;
    @(negedge clk);
    cfg_in_dim = pack(ind); cfg_out_dim = pack(outd); cfg_win = pack(wn);
    cfg_stride = pack(st); cfg_pad = pack(pd);
    done_seen = 0; wr_count = 0; addr_err = 0; width_err = 0; excl_err = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (done_seen == 0 && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 20) begin
        start = 1; cfg_win = '1; cfg_stride = '0; cfg_in_base = 32'h0; cfg_out_base = 32'h10;
      end
      if (poke && cyc == 21) start = 0;
    end
    chk(cyc < 60000, {req, " watchdog"}, 32'(cyc), 32'd60000);
    repeat (3) @(negedge clk);
    cfg_in_base = IBASE; cfg_out_base = OBASE;
    chk(done_seen == 1, "R8 done count", 32'(done_seen), 32'd1);
    chk(width_err == 0, "R8 done width", 32'(width_err), 32'd0);
    chk(wr_count == nout, "R7 write count", 32'(wr_count), 32'(nout));
    chk(addr_err == 0, "R5 address range", 32'(addr_err), 32'd0);
    chk(excl_err == 0, "R11 rd/wr overlap", 32'(excl_err), 32'd0);
    for (int x = 0; x < outd[0]; x++)
      for (int y = 0; y < outd[1]; y++)
        for (int z = 0; z < outd[2]; z++)
          for (int p = 0; p < outd[3]; p++) begin
            logic [31:0] e;
            o[0] = x; o[1] = y; o[2] = z; o[3] = p;
            e = expect_at(o);
            chk(omem[lin(o, outd)] == e, req, omem[lin(o, outd)], e);
          end
  endtask

  initial begin
    #(4 * 190000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!rd_req, "R10 rd_req", 32'(rd_req), 0);
    chk(!wr_req, "R10 wr_req", 32'(wr_req), 0);
    chk(!done, "R10 done", 32'(done), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 / R6: 8x8, 2x2 window stride 2, random stalls
    for (int i = 0; i < MEMN; i++) imem[i] = rnd_float();
    stall_on = 1;
    set6(ind, 8, 8, 1, 1); set6(outd, 4, 4, 1, 1); set6(wn, 2, 2, 1, 1);
    set6(st, 2, 2, 1, 1); set6(pd, 0, 0, 0, 0);
    run_case("R1 R6 8x8 pool", 0);

    // R9: 32x32 with start and config poked mid-run
    for (int i = 0; i < MEMN; i++) imem[i] = rnd_float();
    set6(ind, 32, 32, 1, 1); set6(outd, 16, 16, 1, 1);
    run_case("R9 R1 32x32 pool", 1);

    // R2: overlapping 3x3, stride 1, pad 1
    for (int i = 0; i < MEMN; i++) imem[i] = rnd_float();
    set6(ind, 8, 8, 1, 1); set6(outd, 8, 8, 1, 1); set6(wn, 3, 3, 1, 1);
    set6(st, 1, 1, 1, 1); set6(pd, 1, 1, 0, 0);
    run_case("R2 overlap clip", 0);

    // R5: all four axes active
    set6(ind, 3, 2, 3, 2); set6(outd, 2, 2, 2, 1); set6(wn, 2, 1, 2, 2);
    set6(st, 1, 1, 1, 1); set6(pd, 0, 0, 0, 0);
    run_case("R5 four-axis layout", 0);

    // R4: ties, signed zeros, negatives, -inf
    for (int i = 0; i < MEMN; i++) imem[i] = tie_float();
    stall_on = 0;
    set6(ind, 8, 8, 1, 1); set6(outd, 4, 4, 1, 1); set6(wn, 2, 2, 1, 1);
    set6(st, 2, 2, 1, 1);
    run_case("R4 ordering", 0);

    // R3: windows clipped to nothing
    for (int i = 0; i < MEMN; i++) imem[i] = rnd_float();
    set6(ind, 4, 1, 1, 1); set6(outd, 3, 1, 1, 1); set6(wn, 1, 1, 1, 1);
    set6(st, 1, 1, 1, 1); set6(pd, 2, 0, 0, 0);
    run_case("R3 empty window", 0);
    chk(omem[0] == 32'hFF80_0000, "R3 first output", omem[0], 32'hFF80_0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule